// File: doc/BRIEF.md
# Gated Multi-Input Trigger Timestamper

This block puts a time on external trigger signals. The time is measured against the detector's 40 MHz master clock. Each trigger channel arrives already sampled: in every system clock cycle it supplies 32 oversampled bits, and bit 0 is the earliest sample in time. The block finds the first rising edge in each word. It combines the bit index of that edge (the fine bin, 0.78125 ns per step) with a free-running count of clock cycles (the coarse count). It also derives a bunch-crossing number that advances once every 160 cycles.

Triggers are recorded only while acquisition is active. Two single-cycle pulses from the control path open and close the acquisition window. Both pulses also leave their own tagged records in the output stream, so downstream software can place every trigger inside its window. Every record is 128 bits wide. Records collect in an output queue that is read over a valid/ready port. When the queue is full, new records are dropped and a sticky loss flag is raised.

Top module: `trig_stamper`

## Requirements
- R1: There are four trigger channels. Each channel has its own 32-bit sample word per cycle, and channel c occupies bits [32c+31:32c] of the sample bus. A cycle in which a channel shows a rising edge while the window is open produces one record of kind 0x01 whose channel field is c.
- R2: The fine bin is the index of the first 0-to-1 step in the word, with bit 0 earliest. The bit that precedes bit 0 is bit 31 of the same channel's word from the cycle before. So an edge at bin 0 is seen only if that earlier bit was 0, and a word of all ones after a cycle ending in 1 has no edge.
- R3: When a channel's word holds several rising edges, only the earliest is recorded. The later ones produce nothing.
- R4: The window opens in the cycle of a start pulse (triggers in that cycle count) and closes in the cycle of a stop pulse (triggers in that cycle are dropped). Rising edges outside the window produce no record.
- R5: A start pulse writes a record of kind 0x02. A stop pulse writes a record of kind 0x03, but only while the window is open. Both records carry channel 0 and fine bin 0.
- R6: Record field positions are: bits [7:0] kind, [15:8] channel, [31:16] bunch-crossing number, [95:32] timestamp, [127:96] event number. The timestamp equals coarse*32 + fine bin. The coarse count is the number of cycles since the latest start pulse, and the start cycle itself has coarse 0.
- R7: The bunch-crossing number equals the coarse count divided by 160 (integer division), kept to 16 bits.
- R8: The event number of a start record is 0. Each further record produced, including records lost to a full queue, takes the next number. A stop pulse does not reset the numbering.
- R9: Records produced in the same cycle are queued in this order: start record, then trigger records in ascending channel order, then the stop record. All of them use that cycle's coarse count.
- R10: The read port is first-word-fall-through with 16 entries. A record produced in cycle t is visible on the port from cycle t+1. A record is consumed on a cycle where valid and ready are both high, and the head stays stable while it waits.
- R11: When the queue cannot take every record produced in a cycle, the later records in the R9 order are dropped. The overflow flag then rises in the next cycle and stays high until a start pulse. A start pulse clears the flag, except when records are dropped in that same cycle.
- R12: After reset the window is closed, the queue is empty and the overflow flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz detector system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_start_i | input | 1 | One-cycle pulse that opens the acquisition window |
| acq_stop_i | input | 1 | One-cycle pulse that closes the acquisition window |
| trig_samp_i | input | 128 | Oversampled words, 32 bits per channel, bit 0 earliest |
| rd_ready_i | input | 1 | Consumer accepts the head record |
| rd_valid_o | output | 1 | A record is available |
| rd_data_o | output | 128 | Head record |
| overflow_o | output | 1 | Sticky flag: records were lost to a full queue |

## Verification
Most wrong internal state shows up in the very next record. The coarse counter, the bunch-crossing counter and the event number all appear in every record, so a slipped count differs from the arithmetic expectation as soon as the following record is read. A wrong carried-over bit 31 shows up only when a word starts with a 1 after a cycle ending in 0, or the reverse; the bench therefore forces both orders. A queue pointer or count fault shows as a reordered record, a missing record, or an overflow flag that is out of step with the number of records produced. In the bench's read-behind pattern this appears within a few cycles of the fault.

// File: rtl/trig_stamper_pkg.sv
// Shared widths and record layout for the trigger timestamper.
// Assumes byte 0 of a record sits in the least significant bits.
package trig_stamper_pkg;
    localparam int REC_W    = 128;
    localparam int COARSE_W = 59;
    localparam int BXID_W   = 16;
    localparam int EVT_W    = 32;

    typedef enum logic [7:0] {
        REC_TRIG  = 8'h01,
        REC_START = 8'h02,
        REC_STOP  = 8'h03
    } rec_kind_e;

    typedef struct packed {
        logic [EVT_W-1:0]  evt;
        logic [63:0]       stamp;
        logic [BXID_W-1:0] bxid;
        logic [7:0]        chan;
        rec_kind_e         kind;
    } rec_t;
endpackage

// File: rtl/ts_edge_finder.sv
// Finds the first rising edge inside one channel's oversampled word.
// Assumes bit 0 is the earliest sample; the previous word's top bit
// is kept as the predecessor of bit 0.
module ts_edge_finder #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  vec_i,
    output logic          hit_o,
    output logic [IW-1:0] bin_o
);
    logic         prev_q;
    logic [W-1:0] trans;

    // Hold the latest sample of the previous word.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= vec_i[W-1];
    end

    // Mark every 0-to-1 step, then pick the lowest one.
    always_comb begin
        trans = vec_i & ~{vec_i[W-2:0], prev_q};
        hit_o = |trans;
        bin_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (trans[i]) bin_o = IW'(i);
        end
    end

    // R2 R3
    earliest_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (trans[bin_o] && ((trans & ((W'(1) << bin_o) - W'(1))) == '0)));
endmodule

// File: rtl/ts_timebase.sv
// Coarse cycle count, bunch-crossing count, acquisition window and
// event numbering. Presents the current cycle's values; a start pulse
// forces them to zero in the same cycle.
module ts_timebase #(
    parameter int BX_DIV   = 160,
    parameter int COARSE_W = 59,
    parameter int BXID_W   = 16,
    parameter int EVT_W    = 32,
    parameter int GEN_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic [GEN_W-1:0]    n_gen_i,
    output logic                gate_o,
    output logic                emit_stop_o,
    output logic [COARSE_W-1:0] coarse_o,
    output logic [BXID_W-1:0]   bxid_o,
    output logic [EVT_W-1:0]    evt_base_o
);
    localparam int SUB_W = $clog2(BX_DIV);

    logic                act_q;
    logic [COARSE_W-1:0] coarse_q;
    logic [SUB_W-1:0]    sub_q, sub_cur;
    logic [BXID_W-1:0]   bx_q;
    logic [EVT_W-1:0]    evt_q;

    // Current-cycle values, with start forcing a fresh origin.
    always_comb begin
        gate_o      = stop_i ? 1'b0 : (start_i | act_q);
        emit_stop_o = stop_i & act_q;
        coarse_o    = start_i ? '0 : coarse_q;
        sub_cur     = start_i ? '0 : sub_q;
        bxid_o      = start_i ? '0 : bx_q;
        evt_base_o  = start_i ? '0 : evt_q;
    end

    // Advance counters and window state once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            coarse_q <= '0;
            sub_q    <= '0;
            bx_q     <= '0;
            evt_q    <= '0;
        end else begin
            act_q    <= gate_o;
            coarse_q <= coarse_o + COARSE_W'(1);
            if (sub_cur == SUB_W'(BX_DIV - 1)) begin
                sub_q <= '0;
                bx_q  <= bxid_o + BXID_W'(1);
            end else begin
                sub_q <= sub_cur + SUB_W'(1);
                bx_q  <= bxid_o;
            end
            evt_q <= evt_base_o + EVT_W'(n_gen_i);
        end
    end

    // R6
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (coarse_q == COARSE_W'(1)));
    // R7
    bx_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q < SUB_W'(BX_DIV));
    // R4
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !act_q);
endmodule

// File: rtl/ts_fifo.sv
// Record queue taking several ranked writes per cycle, one read per
// cycle, first-word-fall-through. Assumes DEPTH is a power of two and
// the ranks of requesting slots are 0,1,2,... without gaps.
module ts_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 16,
    parameter int NSLOT = 6,
    parameter int RW    = $clog2(NSLOT + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSLOT-1:0]           req_i,
    input  logic [NSLOT-1:0][RW-1:0]   rank_i,
    input  logic [NSLOT-1:0][W-1:0]    data_i,
    input  logic [RW-1:0]              n_req_i,
    input  logic                       clr_ovf_i,
    input  logic                       rd_ready_i,
    output logic                       rd_valid_o,
    output logic [W-1:0]               rd_data_o,
    output logic                       ovf_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    space, n_acc;
    logic [NSLOT-1:0] accept;
    logic             pop, drop;

    // Decide which ranked writes fit into the free space.
    always_comb begin
        space = CW'(DEPTH) - cnt_q;
        for (int k = 0; k < NSLOT; k++) begin
            accept[k] = req_i[k] && (int'(rank_i[k]) < int'(space));
        end
        drop       = int'(n_req_i) > int'(space);
        n_acc      = drop ? space : CW'(n_req_i);
        rd_valid_o = cnt_q != '0;
        rd_data_o  = mem[rd_ptr_q];
        pop        = rd_valid_o && rd_ready_i;
    end

    // Store accepted records at consecutive positions.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NSLOT; k++) begin
            if (accept[k]) mem[wr_ptr_q + AW'(rank_i[k])] <= data_i[k];
        end
    end

    // Pointers, fill level and sticky loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            ovf_o    <= 1'b0;
        end else begin
            wr_ptr_q <= wr_ptr_q + AW'(n_acc);
            rd_ptr_q <= rd_ptr_q + AW'(pop);
            cnt_q    <= cnt_q + n_acc - CW'(pop);
            if (drop)           ovf_o <= 1'b1;
            else if (clr_ovf_i) ovf_o <= 1'b0;
        end
    end

    // R10
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));
    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_o) |-> $past(clr_ovf_i));
endmodule

// File: rtl/trig_stamper.sv
// Top of the gated trigger timestamper: per-channel edge finders, the
// timebase, record packing in fixed slot order and the output queue.
// Assumes start and stop are single-cycle pulses on the system clock.
module trig_stamper
    import trig_stamper_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int SAMP_W     = 32,
    parameter int BX_DIV     = 160,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acq_start_i,
    input  logic                     acq_stop_i,
    input  logic [N_CH*SAMP_W-1:0]   trig_samp_i,
    input  logic                     rd_ready_i,
    output logic                     rd_valid_o,
    output logic [REC_W-1:0]         rd_data_o,
    output logic                     overflow_o
);
    localparam int FINE_W = $clog2(SAMP_W);
    localparam int NSLOT  = N_CH + 2;
    localparam int RW     = $clog2(NSLOT + 1);

    logic [N_CH-1:0]              hit;
    logic [N_CH-1:0][FINE_W-1:0]  bin;
    logic                         gate, emit_stop;
    logic [COARSE_W-1:0]          coarse;
    logic [BXID_W-1:0]            bxid;
    logic [EVT_W-1:0]             evt_base;
    logic [NSLOT-1:0]             req;
    logic [NSLOT-1:0][RW-1:0]     rank;
    logic [NSLOT-1:0][REC_W-1:0]  recs;
    logic [RW-1:0]                n_gen;

    // One edge finder per channel.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        ts_edge_finder #(.W(SAMP_W), .IW(FINE_W)) finder_i (
            .clk   (clk),
            .rst_n (rst_n),
            .vec_i (trig_samp_i[c*SAMP_W +: SAMP_W]),
            .hit_o (hit[c]),
            .bin_o (bin[c])
        );
    end

    ts_timebase #(
        .BX_DIV(BX_DIV), .COARSE_W(COARSE_W), .BXID_W(BXID_W),
        .EVT_W(EVT_W), .GEN_W(RW)
    ) tb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (acq_start_i),
        .stop_i      (acq_stop_i),
        .n_gen_i     (n_gen),
        .gate_o      (gate),
        .emit_stop_o (emit_stop),
        .coarse_o    (coarse),
        .bxid_o      (bxid),
        .evt_base_o  (evt_base)
    );

    // Slot requests and their ranks: start, channels ascending, stop.
    always_comb begin
        logic [RW-1:0] run;
        req[0] = acq_start_i;
        for (int c = 0; c < N_CH; c++) req[c+1] = gate & hit[c];
        req[NSLOT-1] = emit_stop;
        run = '0;
        for (int s = 0; s < NSLOT; s++) begin
            rank[s] = run;
            run     = run + RW'(req[s]);
        end
        n_gen = run;
    end

    // Pack one record per slot from this cycle's timebase values.
    always_comb begin
        rec_t r;
        for (int s = 0; s < NSLOT; s++) begin
            r.evt  = evt_base + EVT_W'(rank[s]);
            r.bxid = bxid;
            if (s == 0) begin
                r.kind  = REC_START;
                r.chan  = 8'd0;
                r.stamp = 64'(coarse) << FINE_W;
            end else if (s == NSLOT - 1) begin
                r.kind  = REC_STOP;
                r.chan  = 8'd0;
                r.stamp = 64'(coarse) << FINE_W;
            end else begin
                r.kind  = REC_TRIG;
                r.chan  = 8'(s - 1);
                r.stamp = (64'(coarse) << FINE_W) | 64'(bin[s-1]);
            end
            recs[s] = r;
        end
    end

    ts_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH), .NSLOT(NSLOT), .RW(RW)) q_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .rank_i     (rank),
        .data_i     (recs),
        .n_req_i    (n_gen),
        .clr_ovf_i  (acq_start_i),
        .rd_ready_i (rd_ready_i),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .ovf_o      (overflow_o)
    );
endmodule

// File: tb/trig_stamper_tb_top.sv
// Bench: drives sample words and control pulses, models the records
// arithmetically from the requirements, and compares queue contents.
module trig_stamper_tb_top;
    localparam int NCH = 4;
    localparam int DEP = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acq_start = 1'b0, acq_stop = 1'b0, rd_ready = 1'b0;
    logic [127:0] trig = '0;
    logic         rd_valid, overflow;
    logic [127:0] rd_data;

    int n_chk = 0, n_bad = 0;

    // Model state
    logic [127:0] exp_q[$];
    longint       m_coarse = 0;
    int unsigned  m_evt = 0;
    bit           m_act = 0, m_ovf = 0;
    bit [3:0]     m_prev = '0;

    always #2 clk = ~clk;

    trig_stamper dut_i (
        .clk(clk), .rst_n(rst_n), .acq_start_i(acq_start), .acq_stop_i(acq_stop),
        .trig_samp_i(trig), .rd_ready_i(rd_ready), .rd_valid_o(rd_valid),
        .rd_data_o(rd_data), .overflow_o(overflow)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input int kind, input int ch, input longint coarse,
                                        input int bin, input int unsigned evt);
        logic [127:0] r;
        r[7:0]    = 8'(kind);
        r[15:8]   = 8'(ch);
        r[31:16]  = 16'(coarse / 160);
        r[95:32]  = 64'(coarse * 32 + bin);
        r[127:96] = evt;
        return r;
    endfunction

    // Advance the arithmetic model by one cycle (occ = entries before this edge).
    task automatic model(input bit st, input bit sp, input logic [127:0] v, input int occ);
        longint      cc;
        int unsigned base;
        bit          nact, estop;
        int          k, bin;
        cc    = st ? 0 : m_coarse;
        base  = st ? 0 : m_evt;
        nact  = sp ? 0 : (st ? 1 : m_act);
        estop = sp && m_act;
        if (st) m_ovf = 0;
        k = 0;
        if (st) begin
            if (k < DEP - occ) exp_q.push_back(mk(2, 0, cc, 0, base + k)); else m_ovf = 1;
            k++;
        end
        for (int c = 0; c < NCH; c++) begin
            bin = -1;
            for (int i = 31; i >= 0; i--) begin
                if (v[c*32+i] && !((i == 0) ? m_prev[c] : v[c*32+i-1])) bin = i;
            end
            if (bin >= 0 && nact) begin
                if (k < DEP - occ) exp_q.push_back(mk(1, c, cc, bin, base + k)); else m_ovf = 1;
                k++;
            end
            m_prev[c] = v[c*32+31];
        end
        if (estop) begin
            if (k < DEP - occ) exp_q.push_back(mk(3, 0, cc, 0, base + k)); else m_ovf = 1;
            k++;
        end
        m_evt    = base + k;
        m_coarse = cc + 1;
        m_act    = nact;
    endtask

    // One cycle, called at a falling edge: optional read, drive, model, advance.
    task automatic tick(input bit st, input bit sp, input logic [127:0] v, input bit rd);
        int occ;
        occ = exp_q.size();
        rd_ready = 1'b0;
        chk(overflow == m_ovf, "R11 overflow flag", 128'(overflow), 128'(m_ovf));
        if (rd) begin
            chk(rd_valid == (occ != 0), "R10 valid", 128'(rd_valid), 128'(occ != 0));
            if (occ != 0 && rd_valid) begin
                case (exp_q[0][7:0])
                    8'h01:   chk(rd_data === exp_q[0], "R1 R2 R3 R6 R7 R8 R9 trigger record", rd_data, exp_q[0]);
                    8'h02:   chk(rd_data === exp_q[0], "R5 R6 R8 start record", rd_data, exp_q[0]);
                    default: chk(rd_data === exp_q[0], "R5 R8 R9 stop record", rd_data, exp_q[0]);
                endcase
                void'(exp_q.pop_front());
                rd_ready = 1'b1;
            end
        end
        acq_start = st;
        acq_stop  = sp;
        trig      = v;
        model(st, sp, v, occ);
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [127:0] on_ch(input int ch, input logic [31:0] w);
        return 128'(w) << (ch * 32);
    endfunction

    function automatic logic [127:0] all_ch(input logic [31:0] w);
        return {w, w, w, w};
    endfunction

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pats [6];
        pats = '{32'h0000_0F0F, 32'hA5A5_A5A5, 32'h8000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0001};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk(rd_valid == 1'b0, "R12 empty after reset", 128'(rd_valid), 128'(0));
        chk(overflow == 1'b0, "R12 overflow low after reset", 128'(overflow), 128'(0));

        // R4: edges before any start are ignored
        for (int i = 0; i < 10; i++) tick(0, 0, (i % 2) ? all_ch(32'h0000_0100) : '0, 1);
        chk(rd_valid == 1'b0, "R4 nothing queued while closed", 128'(rd_valid), 128'(0));

        // R2 sweep of every fine bin on every channel
        tick(1, 0, '0, 1);
        for (int b = 0; b < 32; b++) begin
            for (int c = 0; c < NCH; c++) begin
                tick(0, 0, on_ch(c, 32'hFFFF_FFFF << b), 1);
                tick(0, 0, '0, 1);
            end
        end

        // R3 and predecessor-bit patterns, all channels at once (R9 order)
        for (int p = 0; p < 6; p++) begin
            tick(0, 0, all_ch(pats[p]), 1);
            repeat (4) tick(0, 0, '0, 1);
        end
        tick(0, 0, all_ch(32'h8000_0000), 1);
        tick(0, 0, all_ch(32'hFFFF_FFFF), 1);
        tick(0, 0, '0, 1);
        tick(0, 0, {32'h0000_0010, 32'h0001_0000, 32'h4000_0000, 32'h0000_0003}, 1);
        repeat (4) tick(0, 0, '0, 1);

        // R7: run across several bunch crossings
        for (int i = 0; i < 400; i++)
            tick(0, 0, (i % 37 == 0) ? on_ch(i % 4, 32'h1 << (i % 32)) : '0, 1);

        // R4 R5: stop drops same-cycle triggers, later edges ignored
        tick(0, 1, all_ch(32'h0000_0100), 1);
        for (int i = 0; i < 5; i++) tick(0, 0, (i % 2) ? '0 : all_ch(32'h0000_0100), 1);
        tick(0, 1, '0, 1);
        repeat (4) tick(0, 0, '0, 1);

        // R4: trigger in the start cycle is kept; R8 numbering restarts
        tick(1, 0, all_ch(32'h0000_0002), 1);
        repeat (6) tick(0, 0, '0, 1);

        // R11: overflow, stays set across drain, cleared by start
        for (int i = 0; i < 6; i++) tick(0, 0, all_ch(32'h0000_0001), 0);
        chk(overflow == 1'b1, "R11 overflow set", 128'(overflow), 128'(1));
        repeat (20) tick(0, 0, '0, 1);
        chk(overflow == 1'b1, "R11 overflow still set", 128'(overflow), 128'(1));
        tick(1, 0, '0, 1);
        chk(overflow == 1'b0, "R11 cleared by start", 128'(overflow), 128'(0));
        repeat (4) tick(0, 0, all_ch(32'h0000_0001), 0);
        repeat (24) tick(0, 0, '0, 1);
        tick(1, 0, all_ch(32'h0000_0001), 1);
        repeat (24) tick(0, 0, '0, 1);
        chk(exp_q.size() == 0, "R10 model drained", 128'(exp_q.size()), 128'(0));

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule